// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block decides which analog input an eight-input converter samples on each serial transfer. A serial front end, outside this block, raises a one-cycle `frame_start` strobe when a transfer begins. At that moment the block fixes the channel to be converted and holds it on `conv_ch` for the whole transfer. When the transfer ends, the front end raises `frame_end` together with the control fields it captured: write enable, two mode bits and a channel address field. On a mask-load frame it also supplies an enable mask. Those fields decide the channel for the following transfer.

Four ways of choosing the channel are supported:

- A fixed single channel.
- A walk through an enable mask in ascending order, with wrap-around.
- A count from channel 0 up to a limit taken from the address field.
- A "continue" pattern, which lets software rewrite the control word without disturbing a running sequence.

A pending flag, `shadow_load`, tells the front end that the next transfer carries the enable mask rather than a control word.

Top module: `adc_chan_sequencer`

## Requirements
- R1: A frame end with `wr_en`=1, `seq_sel`=0 and `shadow_sel`=0 selects single mode. The next frame, and every frame after it until another write, converts channel `addr`.
- R2: A frame end with `wr_en`=1, `seq_sel`=0 and `shadow_sel`=1 raises `shadow_load` one cycle later. The next frame converts `addr`. At that frame's end, `mask_in` is stored whatever the control fields hold, and `shadow_load` falls. Bit i of the mask enables channel i.
- R3: The first frame after a mask load converts the lowest channel enabled in the mask.
- R4: In mask mode, each later frame converts the next higher enabled channel. After the highest enabled channel, the sequence wraps to the lowest enabled channel, with no further writes.
- R5: A frame end with `wr_en`=1, `seq_sel`=1 and `shadow_sel`=1 starts a count. The following frames convert 0, 1, ..., `addr` and then restart at 0. The stored mask plays no part in this mode.
- R6: A frame end with `wr_en`=0, outside a mask-load frame, leaves the mode, the limit, the mask and the sequence position as they were. Only the normal per-frame advance takes place.
- R7: A frame end with `wr_en`=1, `seq_sel`=1 and `shadow_sel`=0 continues the running sequence exactly as if no write had occurred.
- R8: A write with any pattern other than `seq_sel`=1 with `shadow_sel`=0 abandons the running sequence and applies the new mode from the next frame.
- R9: If the loaded mask is all zeros, every frame in mask mode converts channel 0.
- R10: After reset, `conv_ch` is 0, `shadow_load` is 0, and the block is in single mode on channel 0 with an all-zero mask.
- R11: `conv_ch` changes only in the cycle after `frame_start`, so it stays fixed for the whole of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of a serial transfer |
| frame_end | input | 1 | One-cycle strobe at the end of a transfer; qualifies the field inputs |
| wr_en | input | 1 | Captured write-enable bit of the control word |
| seq_sel | input | 1 | Captured sequence mode bit |
| shadow_sel | input | 1 | Captured shadow mode bit |
| addr | input | CH_W (3) | Captured channel address / count limit |
| mask_in | input | NUM_CH (8) | Enable mask captured during a mask-load frame |
| conv_ch | output | CH_W (3) | Channel to convert in the current frame |
| shadow_load | output | 1 | Next frame carries the enable mask |

## Verification
On every cycle, the assertions check several properties:

- `conv_ch` holds steady outside the cycle after a frame start.
- In mask mode, the upcoming channel is always an enabled one whenever the mask is non-zero.
- In count mode, the upcoming channel never exceeds the limit.
- A mask-load frame always clears the pending flag and enters mask mode.
- A frame end with no write in single mode leaves the position untouched.

Only the bench scenarios can show the actual channel orders: the ascending walk and wrap over particular masks, the 0-to-limit count, and a continue write that leaves a sequence running. They also show a mode change landing on exactly the next frame.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_MASK   = 2'd1,
      MODE_COUNT  = 2'd2
   } seq_mode_e;

endpackage

// File: rtl/adc_mask_picker.sv
module adc_mask_picker #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   cur,
   output logic [CH_W-1:0]   first_ch,
   output logic [CH_W-1:0]   succ_ch
);

   logic [NUM_CH-1:0] above;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_above
      assign above[g] = mask[g] && (CH_W'(g) > cur);
   end

   always_comb begin
      first_ch = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i]) first_ch = CH_W'(i);
      end
   end

   always_comb begin
      succ_ch = first_ch;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (above[i]) succ_ch = CH_W'(i);
      end
   end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_end,
   input  logic              wr_en,
   input  logic              seq_sel,
   input  logic              shadow_sel,
   input  logic [CH_W-1:0]   addr,
   input  logic [NUM_CH-1:0] mask_in,
   output logic [CH_W-1:0]   next_ch,
   output logic              pend_mask
);

   seq_mode_e         mode_q;
   logic [CH_W-1:0]   next_q;
   logic [CH_W-1:0]   limit_q;
   logic [NUM_CH-1:0] mask_q;
   logic              pend_q;

   logic [CH_W-1:0]   succ_ch;
   logic [CH_W-1:0]   unused_first;
   logic [CH_W-1:0]   load_first;
   logic [CH_W-1:0]   unused_succ;
   logic              keep_seq;

   adc_mask_picker #(.NUM_CH(NUM_CH)) u_run (
      .mask(mask_q), .cur(next_q), .first_ch(unused_first), .succ_ch(succ_ch)
   );

   adc_mask_picker #(.NUM_CH(NUM_CH)) u_load (
      .mask(mask_in), .cur('0), .first_ch(load_first), .succ_ch(unused_succ)
   );

   assign keep_seq = !wr_en || (seq_sel && !shadow_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_SINGLE;
         next_q  <= '0;
         limit_q <= '0;
         mask_q  <= '0;
         pend_q  <= 1'b0;
      end else if (frame_end) begin
         if (pend_q) begin
            mask_q <= mask_in;
            mode_q <= MODE_MASK;
            next_q <= load_first;
            pend_q <= 1'b0;
         end else if (!keep_seq) begin
            if (seq_sel) begin
               mode_q  <= MODE_COUNT;
               limit_q <= addr;
               next_q  <= '0;
            end else begin
               mode_q <= MODE_SINGLE;
               next_q <= addr;
               pend_q <= shadow_sel;
            end
         end else begin
            unique case (mode_q)
               MODE_MASK:  next_q <= succ_ch;
               MODE_COUNT: next_q <= (next_q == limit_q) ? '0 : next_q + 1'b1;
               default:    next_q <= next_q;
            endcase
         end
      end
   end

   assign next_ch   = next_q;
   assign pend_mask = pend_q;

   p_mask_member_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_MASK && mask_q != '0) |-> mask_q[next_q]);

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_COUNT) |-> (next_q <= limit_q));

   p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !pend_q && !wr_en && mode_q == MODE_SINGLE) |=> $stable(next_q));

   p_shadow_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && pend_q) |=> (!pend_q && mode_q == MODE_MASK));

   p_continue_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && !pend_q && wr_en && seq_sel && !shadow_sel)
         |=> ($stable(mode_q) && $stable(limit_q) && $stable(mask_q)));

endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer #(
   parameter int NUM_CH = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              frame_end,
   input  logic              wr_en,
   input  logic              seq_sel,
   input  logic              shadow_sel,
   input  logic [CH_W-1:0]   addr,
   input  logic [NUM_CH-1:0] mask_in,
   output logic [CH_W-1:0]   conv_ch,
   output logic              shadow_load
);

   initial begin
      if (NUM_CH < 2 || (1 << CH_W) != NUM_CH)
         $error("NUM_CH must be a power of two of at least 2");
   end

   logic [CH_W-1:0] next_ch;
   logic [CH_W-1:0] conv_q;

   adc_seq_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
      .wr_en(wr_en), .seq_sel(seq_sel), .shadow_sel(shadow_sel),
      .addr(addr), .mask_in(mask_in),
      .next_ch(next_ch), .pend_mask(shadow_load)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           conv_q <= '0;
      else if (frame_start) conv_q <= next_ch;
   end

   assign conv_ch = conv_q;

   p_frame_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(conv_ch));

endmodule

// File: tb/tb_adc_chan_sequencer.sv
module tb_adc_chan_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH = 8;
   localparam int CH_W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_start = 1'b0, frame_end = 1'b0;
   logic wr_en = 1'b0, seq_sel = 1'b0, shadow_sel = 1'b0;
   logic [CH_W-1:0] addr = '0;
   logic [NUM_CH-1:0] mask_in = '0;
   logic [CH_W-1:0] conv_ch;
   logic shadow_load;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state: 0 single, 1 mask, 2 count
   int m_mode = 0;
   int m_next = 0, m_limit = 0;
   logic [NUM_CH-1:0] m_mask = '0;
   bit m_pend = 1'b0;

   adc_chan_sequencer #(.NUM_CH(NUM_CH)) dut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
      .wr_en(wr_en), .seq_sel(seq_sel), .shadow_sel(shadow_sel), .addr(addr),
      .mask_in(mask_in), .conv_ch(conv_ch), .shadow_load(shadow_load)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int lowest(input logic [NUM_CH-1:0] m);
      for (int i = 0; i < NUM_CH; i++) if (m[i]) return i;
      return 0;
   endfunction

   function automatic int succ(input logic [NUM_CH-1:0] m, input int c);
      for (int i = c + 1; i < NUM_CH; i++) if (m[i]) return i;
      return lowest(m);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one transfer; returns after frame end has been applied
   task automatic frame(input string req, input bit w, input bit s, input bit h,
                        input int a, input logic [NUM_CH-1:0] m);
      int exp_ch;
      exp_ch = m_next;
      @(negedge clk) frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
      check({req, " conv_ch"}, int'(conv_ch), exp_ch);
      repeat (2) @(negedge clk);
      check("R11 conv_ch held in frame", int'(conv_ch), exp_ch);
      frame_end = 1'b1; wr_en = w; seq_sel = s; shadow_sel = h;
      addr = CH_W'(a); mask_in = m;
      @(negedge clk) frame_end = 1'b0;
      // model update
      if (m_pend) begin
         m_mask = m; m_mode = 1; m_next = lowest(m); m_pend = 1'b0;
      end else if (w && !(s && !h)) begin
         if (s) begin m_mode = 2; m_limit = a; m_next = 0; end
         else   begin m_mode = 0; m_next = a; m_pend = h; end
      end else begin
         if (m_mode == 1) m_next = succ(m_mask, m_next);
         else if (m_mode == 2) m_next = (m_next == m_limit) ? 0 : m_next + 1;
      end
      check("R2 shadow_load", int'(shadow_load), int'(m_pend));
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset conv_ch", int'(conv_ch), 0);
      check("R10 reset shadow_load", int'(shadow_load), 0);
      frame("R10 first frame ch0", 0, 0, 0, 5, '0);
      // R1 single channel
      frame("R1 write single 5", 1, 0, 0, 5, '0);
      frame("R1 single 5", 0, 0, 0, 1, '0);
      frame("R6 no write keeps 5", 0, 1, 1, 2, '1);
      // R2 shadow write, then mask frame with junk control
      frame("R2 request mask", 1, 0, 1, 3, '0);
      frame("R2 mask frame on addr", 1, 0, 0, 6, 8'b1010_0100);
      frame("R3 lowest enabled", 0, 0, 0, 0, '0);
      frame("R4 next higher", 0, 0, 0, 0, '0);
      frame("R7 continue write", 1, 1, 0, 1, '0);
      frame("R4 wrap to lowest", 0, 0, 0, 0, '0);
      frame("R4 after wrap", 0, 0, 0, 0, '0);
      // R5 count up to 3, R8 interrupts mask sequence
      frame("R8 count write", 1, 1, 1, 3, '0);
      for (int k = 0; k < 6; k++) frame("R5 count", (k == 2), 1, 0, 0, '1);
      frame("R8 single write", 1, 0, 0, 6, '0);
      frame("R8 single 6", 0, 0, 0, 0, '0);
      // R9 all-zero mask
      frame("R9 request", 1, 0, 1, 2, '0);
      frame("R9 load zero", 0, 0, 0, 0, '0);
      for (int k = 0; k < 3; k++) frame("R9 zero mask ch0", 0, 0, 0, 0, '0);
      // single-bit mask at top channel
      frame("R4 request", 1, 0, 1, 0, '0);
      frame("R4 load top", 0, 0, 0, 0, 8'b1000_0000);
      frame("R4 single bit repeat", 0, 0, 0, 0, '0);
      frame("R4 single bit repeat", 0, 0, 0, 0, '0);
      // random frames
      for (int k = 0; k < 400; k++) begin
         int r;
         r = $urandom_range(0, 9);
         frame("R6 random", (r < 4), $urandom_range(0, 1) == 1,
               $urandom_range(0, 1) == 1, $urandom_range(0, NUM_CH - 1),
               NUM_CH'($urandom));
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule